// File: doc/BRIEF.md
# Flash Sector Protection Guard

This block sits between a host register bus and a serial NOR flash controller and keeps protected sectors from being erased or written. The host writes memory-operation commands into a command register. A command can ask for a bulk erase, for an erase of one 64 KiB sector, or for a new protection setting. The protection setting is a 4-bit protect code and a top/bottom select bit. Together they describe a region that is a power-of-two number of sectors, anchored either at address 0 or at the top of the device. The device size comes from the low byte of a device-identification input.

Each erase command and each write seen on the memory-window snoop port is accepted in the idle state. It spends one evaluation cycle being checked against the protected region. If it falls inside the region, the block raises a sticky flag (illegal erase or illegal write) and nothing goes to the flash controller. Otherwise the block raises a request toward the flash controller with the operation kind and byte address, and holds it until the controller acknowledges. The flags are cleared by writing 1 to them, and they drive an interrupt through a mask register. A chip-select register drives an output that selects the flash device.

The sequencer has three states. ST_IDLE accepts work. ST_EVAL is the one-cycle protection check. ST_ISSUE holds the flash request. The transitions are:
- ST_IDLE to ST_EVAL on an erase command or an accepted snoop write.
- ST_EVAL to ST_IDLE when the target is protected.
- ST_EVAL to ST_ISSUE when it is not.
- ST_ISSUE to ST_IDLE on the acknowledge.

Top module: `flash_guard_ctl`

## Requirements
- R1: After reset, every readable register except the two identification words reads 0, and op_req, busy and irq are low.
- R2: Register word offsets are: 0 status, 1 silicon ID, 2 device ID, 3 command (reads 0), 4 interrupt flags, 5 interrupt mask, 6 chip select. Offset 7 reads 0. The status word carries protect code bits 2:0 at bits 4:2, protect code bit 3 at bit 6 and the top/bottom select at bit 5.
- R3: A command write with code 3 in bits 7:0 loads the protect code from bits 11:8 and the top/bottom select from bit 12, visible in the cycle after the write. Code 3 with both fields zero removes all protection.
- R4: Protect code 0 protects nothing. A nonzero code P protects 0x10000 << (P-1) bytes, capped at a device size of 2^(device ID bits 7:0 minus 6) bytes. With select 0 the region ends at the top of the device; with select 1 it starts at address 0.
- R5: Command code 2 erases the sector whose number starts at bit 8. When that sector is unprotected, op_req rises two cycles after the write, with op_kind 2 and op_addr equal to the sector number times 0x10000.
- R6: A sector erase aimed inside the protected region sets interrupt flag bit 0 two cycles after the write and raises no request.
- R7: Command code 1 (bulk erase) issues op_kind 1 with op_addr 0 when the protect code is 0. Otherwise it sets flag bit 0 and issues nothing.
- R8: A snoop write (mw_valid) accepted in idle issues op_kind 0 with its byte address when unprotected. When protected, it sets flag bit 1 and issues nothing.
- R9: op_req stays high with op_kind and op_addr unchanged until op_ack is sampled high, and falls in the next cycle.
- R10: While busy is high, command-register writes and snoop writes have no effect.
- R11: Writing 1 to a bit at offset 4 clears that flag only. A flag stays set, even when the protection changes, until it is cleared.
- R12: The interrupt mask is bits 1:0 at offset 5. irq is high exactly when some flag and its mask bit are both set.
- R13: Writes to offset 6 load a CS_W-bit chip-select value that drives cs_sel and reads back.
- R14: A command with a code other than 1, 2 or 3 has no effect. When an erase command arrives in the same idle cycle as a snoop write, the command is taken and the snoop write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sil_id | input | 32 | Silicon identification word |
| dev_id | input | 32 | Device identification word; bits 7:0 give the size |
| mw_valid | input | 1 | Memory-window write seen |
| mw_addr | input | ADDR_W | Byte address of the snooped write |
| op_req | output | 1 | Flash operation request |
| op_kind | output | 2 | 0 write, 1 bulk erase, 2 sector erase |
| op_addr | output | ADDR_W | Operation byte address |
| op_ack | input | 1 | Flash controller acknowledge |
| busy | output | 1 | Sequencer not idle |
| irq | output | 1 | Masked interrupt |
| cs_sel | output | CS_W | Chip-select value |

## Verification
A protect update appears in the status register one cycle after the command edge. The pass/fail decision of an erase or write is due two edges after its stimulus: the edge that accepts it and the edge that leaves the evaluation state. On that second edge either op_req rises or a flag sets, and irq follows the flag in the same cycle. op_req falls on the edge after op_ack is sampled. The bench keeps a behavioural model that advances on every rising edge from the same inputs. It compares all outputs, including read data for the currently addressed register, 5 ns after each edge while inputs change only on falling edges. Directed checks sample at the falling edge that follows the cycle in which each result is due.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
    localparam int DATA_W      = 32;
    localparam int SECTOR_LOG2 = 16;

    typedef enum logic [2:0] {
        OFS_STATUS = 3'd0,
        OFS_SILID  = 3'd1,
        OFS_DEVID  = 3'd2,
        OFS_CMD    = 3'd3,
        OFS_ISR    = 3'd4,
        OFS_IMR    = 3'd5,
        OFS_CHSEL  = 3'd6
    } reg_ofs_e;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_BULK   = 2'd1,
        OP_SECTOR = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_ISSUE = 2'd2
    } seq_state_e;

    localparam logic [7:0] CMD_BULK    = 8'd1;
    localparam logic [7:0] CMD_SECTOR  = 8'd2;
    localparam logic [7:0] CMD_PROTECT = 8'd3;
endpackage

// File: rtl/fgc_range.sv
module fgc_range
    import fgc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [3:0]        prot_code,
    input  logic              prot_tb,
    input  logic [7:0]        dev_id_lo,
    input  logic              is_bulk,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int         EXT_W   = ADDR_W + 1;
    localparam logic [7:0] MAX_LOG = 8'(ADDR_W);
    localparam logic [7:0] BASE_LOG = 8'(SECTOR_LOG2 - 1);

    logic [7:0]       raw_log;
    logic [7:0]       size_log;
    logic [7:0]       want_log;
    logic [7:0]       len_log;
    logic [EXT_W-1:0] size_v;
    logic [EXT_W-1:0] len_v;
    logic [EXT_W-1:0] addr_x;

    always_comb begin
        raw_log = dev_id_lo - 8'd6;
        if (dev_id_lo < 8'd6) begin
            size_log = 8'd0;
        end else if (raw_log > MAX_LOG) begin
            size_log = MAX_LOG;
        end else begin
            size_log = raw_log;
        end
        want_log = BASE_LOG + {4'd0, prot_code};
        len_log  = (want_log > size_log) ? size_log : want_log;
        size_v   = EXT_W'(1) << size_log;
        len_v    = EXT_W'(1) << len_log;
        addr_x   = {1'b0, addr};
        if (prot_code == 4'd0) begin
            hit = 1'b0;
        end else if (is_bulk) begin
            hit = 1'b1;
        end else if (prot_tb) begin
            hit = (addr_x < len_v);
        end else begin
            hit = (addr_x >= (size_v - len_v));
        end
    end
endmodule

// File: rtl/fgc_csr.sv
module fgc_csr
    import fgc_pkg::*;
#(
    parameter int CS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] sil_id,
    input  logic [DATA_W-1:0] dev_id,
    input  logic              prot_upd,
    input  logic [3:0]        upd_code,
    input  logic              upd_tb,
    input  logic              set_erase,
    input  logic              set_write,
    output logic [3:0]        prot_code,
    output logic              prot_tb,
    output logic              irq,
    output logic [CS_W-1:0]   cs_sel
);
    logic [1:0]      isr_q;
    logic [1:0]      imr_q;
    logic [CS_W-1:0] cs_q;
    logic [3:0]      code_q;
    logic            tb_q;
    logic [1:0]      isr_d;
    logic            unused_csr;

    assign unused_csr = ^reg_wdata;

    always_comb begin
        isr_d = isr_q;
        if (reg_wr && reg_addr == OFS_ISR) begin
            isr_d = isr_d & ~reg_wdata[1:0];
        end
        if (set_erase) isr_d[0] = 1'b1;
        if (set_write) isr_d[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q  <= '0;
            imr_q  <= '0;
            cs_q   <= '0;
            code_q <= '0;
            tb_q   <= 1'b0;
        end else begin
            isr_q <= isr_d;
            if (reg_wr && reg_addr == OFS_IMR)   imr_q <= reg_wdata[1:0];
            if (reg_wr && reg_addr == OFS_CHSEL) cs_q  <= reg_wdata[CS_W-1:0];
            if (prot_upd) begin
                code_q <= upd_code;
                tb_q   <= upd_tb;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: reg_rdata = {25'd0, code_q[3], tb_q, code_q[2:0], 2'b00};
            OFS_SILID:  reg_rdata = sil_id;
            OFS_DEVID:  reg_rdata = dev_id;
            OFS_ISR:    reg_rdata = {30'd0, isr_q};
            OFS_IMR:    reg_rdata = {30'd0, imr_q};
            OFS_CHSEL:  reg_rdata = DATA_W'(cs_q);
            default:    reg_rdata = '0;
        endcase
    end

    assign prot_code = code_q;
    assign prot_tb   = tb_q;
    assign cs_sel    = cs_q;
    assign irq       = |(isr_q & imr_q);

    a_r6_erase_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_erase |=> isr_q[0]);

    a_r8_write_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_write |=> isr_q[1]);

    a_r11_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ISR && reg_wdata[1] && !set_write) |=> !isr_q[1]);

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q[0] && !(reg_wr && reg_addr == OFS_ISR)) |=> isr_q[0]);

    a_r3_code_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_upd |=> $stable(code_q) && $stable(tb_q));
endmodule

// File: rtl/fgc_seq.sv
module fgc_seq
    import fgc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              mw_valid,
    input  logic [ADDR_W-1:0] mw_addr,
    input  logic              hit,
    input  logic              op_ack,
    output logic              cand_bulk,
    output logic [ADDR_W-1:0] cand_addr,
    output logic              op_req,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic              busy,
    output logic              set_erase,
    output logic              set_write,
    output logic              prot_upd,
    output logic [3:0]        upd_code,
    output logic              upd_tb
);
    localparam int SEC_W = ADDR_W - SECTOR_LOG2;

    seq_state_e        state_q, state_d;
    op_kind_e          kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        code;
    logic              erase_cmd;
    logic              prot_cmd;
    logic              take_snoop;
    logic [SEC_W-1:0]  sector;
    logic              unused_seq;

    assign code       = cmd_data[7:0];
    assign erase_cmd  = cmd_wr && (code == CMD_BULK || code == CMD_SECTOR);
    assign prot_cmd   = cmd_wr && (code == CMD_PROTECT);
    assign take_snoop = mw_valid && !erase_cmd && !prot_cmd;
    assign sector     = cmd_data[8 +: SEC_W];
    assign unused_seq = ^cmd_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (erase_cmd || take_snoop) state_d = ST_EVAL;
            ST_EVAL:  state_d = hit ? ST_IDLE : ST_ISSUE;
            ST_ISSUE: if (op_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // candidate capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= OP_WRITE;
            addr_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (erase_cmd) begin
                kind_q <= op_kind_e'(code[1:0]);
                addr_q <= (code == CMD_SECTOR) ? {sector, {SECTOR_LOG2{1'b0}}} : '0;
            end else if (take_snoop) begin
                kind_q <= OP_WRITE;
                addr_q <= mw_addr;
            end
        end
    end

    // outputs
    always_comb begin
        op_req    = 1'b0;
        set_erase = 1'b0;
        set_write = 1'b0;
        prot_upd  = 1'b0;
        unique case (state_q)
            ST_IDLE:  prot_upd = prot_cmd;
            ST_EVAL: begin
                set_erase = hit && (kind_q != OP_WRITE);
                set_write = hit && (kind_q == OP_WRITE);
            end
            ST_ISSUE: op_req = 1'b1;
            default:  op_req = 1'b0;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign cand_bulk = (kind_q == OP_BULK);
    assign cand_addr = addr_q;
    assign op_kind   = kind_q;
    assign op_addr   = addr_q;
    assign upd_code  = cmd_data[11:8];
    assign upd_tb    = cmd_data[12];

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_ack) |=> op_req && $stable(op_addr) && $stable(op_kind));

    a_r9_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_ack) |=> !op_req);

    a_r6_no_issue_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && hit) |=> !op_req);

    a_r10_no_update_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prot_upd);
endmodule

// File: rtl/flash_guard_ctl.sv
module flash_guard_ctl
    import fgc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       sil_id,
    input  logic [31:0]       dev_id,
    input  logic              mw_valid,
    input  logic [ADDR_W-1:0] mw_addr,
    output logic              op_req,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    input  logic              op_ack,
    output logic              busy,
    output logic              irq,
    output logic [CS_W-1:0]   cs_sel
);
    logic              cmd_wr;
    logic              hit;
    logic              cand_bulk;
    logic [ADDR_W-1:0] cand_addr;
    logic              set_erase;
    logic              set_write;
    logic              prot_upd;
    logic [3:0]        upd_code;
    logic              upd_tb;
    logic [3:0]        prot_code;
    logic              prot_tb;

    assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);

    fgc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(reg_wdata),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .hit(hit), .op_ack(op_ack),
        .cand_bulk(cand_bulk), .cand_addr(cand_addr), .op_req(op_req),
        .op_kind(op_kind), .op_addr(op_addr), .busy(busy),
        .set_erase(set_erase), .set_write(set_write), .prot_upd(prot_upd),
        .upd_code(upd_code), .upd_tb(upd_tb)
    );

    fgc_range #(.ADDR_W(ADDR_W)) u_range (
        .prot_code(prot_code), .prot_tb(prot_tb), .dev_id_lo(dev_id[7:0]),
        .is_bulk(cand_bulk), .addr(cand_addr), .hit(hit)
    );

    fgc_csr #(.CS_W(CS_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sil_id(sil_id),
        .dev_id(dev_id), .prot_upd(prot_upd), .upd_code(upd_code),
        .upd_tb(upd_tb), .set_erase(set_erase), .set_write(set_write),
        .prot_code(prot_code), .prot_tb(prot_tb), .irq(irq), .cs_sel(cs_sel)
    );

    a_r7_no_bulk_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_kind == OP_BULK) |-> (prot_code == 4'd0));

    a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_addr != OFS_ISR) || (reg_rdata[1:0] != 2'b00));
endmodule

// File: tb/flash_guard_ctl_tb.sv
module flash_guard_ctl_tb;
    localparam int ADDR_W = 32;
    localparam int CS_W   = 3;
    localparam logic [31:0] DEV = 32'h00BA_2018;
    localparam logic [31:0] SIL = 32'h0000_0017;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = 3'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mw_valid = 1'b0;
    logic [ADDR_W-1:0] mw_addr = '0;
    logic              op_req;
    logic [1:0]        op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic              op_ack = 1'b0;
    logic              busy;
    logic              irq;
    logic [CS_W-1:0]   cs_sel;

    int compared = 0;
    int mismatched = 0;
    int ack_delay = 2;
    int ack_cnt = 0;
    int cycles = 0;

    // behavioural model state
    int          m_state = 0;
    int          m_kind = 0;
    longint      m_addr = 0;
    int          m_p = 0;
    bit          m_tb = 0;
    int          m_isr = 0;
    int          m_imr = 0;
    int          m_cs = 0;

    always #10 clk = ~clk;

    flash_guard_ctl #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sil_id(SIL), .dev_id(DEV),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .op_req(op_req), .op_kind(op_kind),
        .op_addr(op_addr), .op_ack(op_ack), .busy(busy), .irq(irq), .cs_sel(cs_sel)
    );

    task automatic check(string tag, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit in_prot(longint a, int p, bit tb);
        longint size, len;
        size = 64'd1 << (DEV[7:0] - 6);
        if (p == 0) return 1'b0;
        len = 64'h10000 << (p - 1);
        if (len > size) len = size;
        if (tb) return a < len;
        return a >= size - len;
    endfunction

    function automatic longint model_read(int a);
        case (a)
            0: return ((m_p & 7) << 2) | (longint'(m_tb) << 5) | (((m_p >> 3) & 1) << 6);
            1: return SIL;
            2: return DEV;
            4: return m_isr;
            5: return m_imr;
            6: return m_cs;
            default: return 0;
        endcase
    endfunction

    // model steps on each edge, compare 5 ns later
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_kind = 0; m_addr = 0; m_p = 0; m_tb = 0;
            m_isr = 0; m_imr = 0; m_cs = 0;
        end else begin
            int code;
            int nstate;
            code = reg_wdata[7:0];
            nstate = m_state;
            if (reg_wr && reg_addr == 4) m_isr = m_isr & ~int'(reg_wdata[1:0]);
            if (reg_wr && reg_addr == 5) m_imr = reg_wdata[1:0];
            if (reg_wr && reg_addr == 6) m_cs = reg_wdata[CS_W-1:0];
            if (m_state == 0) begin
                if (reg_wr && reg_addr == 3 && (code == 1 || code == 2)) begin
                    m_kind = code;
                    m_addr = (code == 2) ? (longint'(reg_wdata[23:8]) * 64'h10000) : 0;
                    nstate = 1;
                end else if (reg_wr && reg_addr == 3 && code == 3) begin
                    m_p = reg_wdata[11:8];
                    m_tb = reg_wdata[12];
                end else if (mw_valid) begin
                    m_kind = 0;
                    m_addr = mw_addr;
                    nstate = 1;
                end
            end else if (m_state == 1) begin
                bit bad;
                bad = (m_kind == 1) ? (m_p != 0) : in_prot(m_addr, m_p, m_tb);
                if (bad) begin
                    if (m_kind == 0) m_isr = m_isr | 2; else m_isr = m_isr | 1;
                    nstate = 0;
                end else begin
                    nstate = 2;
                end
            end else begin
                if (op_ack) nstate = 0;
            end
            m_state = nstate;
            #5;
            check("R9 op_req", op_req, m_state == 2);
            if (m_state == 2) begin
                check("R5 op_kind", op_kind, m_kind);
                check("R5 op_addr", op_addr, m_addr);
            end
            check("R10 busy", busy, m_state != 0);
            check("R12 irq", irq, (m_isr & m_imr) != 0);
            check("R13 cs_sel", cs_sel, m_cs);
            check("R2 reg_rdata", reg_rdata, model_read(reg_addr));
        end
    end

    // acknowledge generator
    always @(negedge clk) begin
        if (!op_req) begin
            ack_cnt <= 0;
            op_ack  <= 1'b0;
        end else if (ack_cnt >= ack_delay) begin
            op_ack <= 1'b1;
        end else begin
            ack_cnt <= ack_cnt + 1;
            op_ack  <= 1'b0;
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic snoop(logic [ADDR_W-1:0] a);
        @(negedge clk);
        mw_valid = 1'b1; mw_addr = a;
        @(negedge clk);
        mw_valid = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(int a, longint exp, string tag);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // one falling edge after a command: the edge where the result is due
    task automatic expect_issue(int kind, longint addr, string tag);
        @(negedge clk);
        check(tag, op_req, 1);
        check(tag, op_kind, kind);
        check(tag, op_addr, addr);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, 0, "R1 status after reset");
        rd(1, SIL, "R2 silicon id");
        rd(2, DEV, "R2 device id");
        rd(3, 0, "R2 command reads zero");
        rd(4, 0, "R1 isr after reset");
        rd(5, 0, "R1 imr after reset");
        rd(6, 0, "R1 chip select after reset");
        rd(7, 0, "R2 offset 7 reads zero");
        check("R1 op_req after reset", op_req, 0);
        check("R1 irq after reset", irq, 0);

        // R5 unprotected sector erase
        wr(3, (32'd3 << 8) | 32'd2);
        expect_issue(2, 64'h30000, "R5 sector 3 issue");
        settle(8);

        // R3 protect code 1, top
        wr(3, (32'd1 << 8) | 32'd3);
        rd(0, 32'h04, "R3 status code 1 top");
        wr(3, (32'd3 << 8) | 32'd2);
        settle(4);
        rd(4, 1, "R6 erase of top sector flagged");
        wr(3, (32'd2 << 8) | 32'd2);
        expect_issue(2, 64'h20000, "R4 sector 2 outside top region");
        settle(8);

        // R8 snoop writes
        snoop(32'h0003_FFFC);
        settle(4);
        rd(4, 3, "R8 protected write flagged");
        snoop(32'h0002_FFFC);
        expect_issue(0, 64'h2FFFC, "R8 unprotected write issued");
        settle(8);

        // R12 and R11 mask and clear
        wr(5, 2);
        settle(1);
        check("R12 irq with write flag masked in", irq, 1);
        wr(4, 2);
        rd(4, 1, "R11 only bit 1 cleared");
        check("R12 irq low after clear", irq, 0);
        wr(5, 3);
        settle(1);
        check("R12 irq with erase flag", irq, 1);

        // R11 flag persists across range change; R3 bottom code 2
        wr(3, (32'd1 << 12) | (32'd2 << 8) | 32'd3);
        rd(0, 32'h28, "R3 status code 2 bottom");
        rd(4, 1, "R11 flag kept after range change");
        wr(4, 1);
        rd(4, 0, "R11 erase flag cleared");
        snoop(32'h0001_FFFF);
        settle(4);
        rd(4, 2, "R4 bottom region last byte protected");
        wr(4, 3);
        snoop(32'h0002_0000);
        expect_issue(0, 64'h20000, "R4 first byte above bottom region");
        settle(8);
        wr(3, (32'd1 << 8) | 32'd2);
        settle(4);
        rd(4, 1, "R6 sector 1 in bottom region");
        wr(4, 1);

        // R4 cap to device size, R7 bulk blocked
        wr(3, (32'd8 << 8) | 32'd3);
        rd(0, 32'h40, "R3 status code bit 3");
        snoop(32'h0000_0000);
        settle(4);
        rd(4, 2, "R4 capped region covers address 0");
        wr(4, 3);
        wr(3, 32'd1);
        settle(4);
        rd(4, 1, "R7 bulk erase blocked while protected");
        wr(4, 1);

        // R3 clear, R7 bulk allowed
        wr(3, 32'd3);
        rd(0, 0, "R3 all-zero update clears");
        wr(3, 32'd1);
        expect_issue(1, 0, "R7 bulk erase issued");
        settle(8);

        // R10 ignored while busy
        ack_delay = 6;
        wr(3, (32'd0 << 8) | 32'd2);
        settle(1);
        wr(3, (32'd1 << 8) | 32'd3);
        snoop(32'h0000_0100);
        settle(10);
        rd(0, 0, "R10 protect update ignored while busy");
        check("R10 idle after ignored stimulus", busy, 0);
        ack_delay = 2;

        // R14 unknown code and simultaneous stimulus
        wr(3, 32'h0000_0F00);
        rd(0, 0, "R14 code 0 ignored");
        check("R14 no busy after code 0", busy, 0);
        wr(3, 32'h0000_1F05);
        rd(0, 0, "R14 code 5 ignored");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = (32'd1 << 8) | 32'd2;
        mw_valid = 1'b1; mw_addr = 32'h0003_0000;
        @(negedge clk);
        reg_wr = 1'b0; mw_valid = 1'b0;
        expect_issue(2, 64'h10000, "R14 command beats snoop");
        settle(10);

        // R13 chip select
        wr(6, 5);
        settle(1);
        check("R13 cs_sel drives", cs_sel, 5);
        rd(6, 5, "R13 chip select readback");

        settle(4);
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        finish_run();
    end
endmodule